// File: doc/BRIEF.md
# Multiplier modulo 2^16+1 with zero-as-2^16 operands

This block multiplies two 16-bit words in the multiplicative group modulo 65537. The all-zero word stands for 2^16 on both inputs and on the output, so every 16-bit code is a valid group element. It is meant for cipher datapaths that chain such multiplications with additions and XORs.

Each operand is widened to 17 bits. A zero operand becomes 2^16, and any other value gets a leading zero bit. The two widened operands form a 33-bit product. The remainder is found without a divider: the product's upper 17 bits are subtracted from its lower 16 bits. When that difference would be negative, the modulus is added back, which in 16-bit arithmetic means adding one. A remainder of 2^16 is emitted as zero by the same truncation.

The result is registered. It appears on the output one clock edge after the operands are presented.

Top module: `fmul16`

## Requirements
- R1: While `rst` is high at a clock edge, `prod_q` becomes 0x0000 at that edge.
- R2: `prod_q` after a clock edge is a function only of `opnd_a` and `opnd_b` sampled at that edge. Operands held steady over consecutive edges keep `prod_q` unchanged.
- R3: An operand of 0x0000 is treated as 2^16. For `opnd_a` = 0 and a non-zero `opnd_b` = b, the result is (1 − b) mod 2^16; for example, 0 × 0xFFFF gives 0x0002.
- R4: A true result of 65536 is output as 0x0000. For example, 0x0000 × 0x0001 and 0x0001 × 0x0000 both give 0x0000.
- R5: For non-zero operands, `prod_q` equals (a·b) mod 65537. In particular, b = 1 returns a unchanged.
- R6: When the high half of the product exceeds the low half, the wrap correction applies. For example, 0xFFFF × 0xFFFF gives 0x0004, and 0x0000 × 0x0000 gives 0x0001.
- R7: The result does not depend on operand order: a × b equals b × a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 16 | First factor, 0x0000 meaning 2^16 |
| opnd_b | input | 16 | Second factor, 0x0000 meaning 2^16 |
| prod_q | output | 16 | Registered product modulo 65537, 0x0000 meaning 2^16 |

## Verification
The product is due exactly one rising edge after the operands are presented, because a single output register sits behind the combinational datapath. Each scenario drives the operands on a falling edge, waits for the next rising edge, and samples `prod_q` one nanosecond later. The value checked is therefore the one for the operands just applied, and the next operands have not yet arrived. The checker's hold property only counts cycles whose previous edge was outside reset, so a cleared register is never compared with a computed product.

// File: rtl/fmul16_pkg.sv
package fmul16_pkg;
  localparam int unsigned FM_WORD = 16;
  localparam int unsigned FM_WIDE = FM_WORD + 1;
  localparam int unsigned FM_PROD = 2 * FM_WORD + 1;
endpackage

// File: rtl/fmul16_expand.sv
module fmul16_expand #(
  parameter int unsigned W = fmul16_pkg::FM_WORD
) (
  input  logic [W-1:0] word_i,
  output logic [W:0]   wide_o
);
  // zero code stands for 2^W; otherwise prepend a zero bit
  always_comb begin
    if (word_i == '0) wide_o = {1'b1, {W{1'b0}}};
    else              wide_o = {1'b0, word_i};
  end
endmodule

// File: rtl/fmul16_reduce.sv
module fmul16_reduce #(
  parameter int unsigned W = fmul16_pkg::FM_WORD
) (
  input  logic [W:0]   wa_i,
  input  logic [W:0]   wb_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned PW = 2 * W + 1;

  logic [PW:0]  full;
  logic [W-1:0] lo_h;
  logic [W:0]   hi_h;
  logic [W-1:0] diff;
  logic         borrow;

  assign full   = {1'b0, wa_i} * {1'b0, wb_i};
  assign lo_h   = full[W-1:0];
  assign hi_h   = full[PW-1:W];
  assign borrow = ({1'b0, lo_h} < hi_h);
  assign diff   = lo_h - hi_h[W-1:0];
  // negative difference: add modulus, i.e. +1 after truncation
  assign res_o  = diff + {{(W-1){1'b0}}, borrow};

  logic unused_top;
  assign unused_top = full[PW];
endmodule

// File: rtl/fmul16.sv
module fmul16 #(
  parameter int unsigned W = fmul16_pkg::FM_WORD
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] prod_q
);
  logic [W-1:0] words [2];
  logic [W:0]   wides [2];
  logic [W-1:0] prod_d;

  assign words[0] = opnd_a;
  assign words[1] = opnd_b;

  for (genvar g = 0; g < 2; g++) begin : g_expand
    fmul16_expand #(.W(W)) u_exp (
      .word_i (words[g]),
      .wide_o (wides[g])
    );
  end

  fmul16_reduce #(.W(W)) u_red (
    .wa_i  (wides[0]),
    .wb_i  (wides[1]),
    .res_o (prod_d)
  );

  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else     prod_q <= prod_d;
  end
endmodule

// File: rtl/fmul16_chk.sv
module fmul16_chk #(
  parameter int unsigned W = fmul16_pkg::FM_WORD
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] prod_q
);
  logic warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 1'b0;
    else     warm <= 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> prod_q == '0);

  a_r2_hold_steady: assert property (@(posedge clk) disable iff (rst)
    (warm && $stable(opnd_a) && $stable(opnd_b)) |=> $stable(prod_q));

  a_r3_zero_is_2_16: assert property (@(posedge clk) disable iff (rst)
    (opnd_a == '0 && opnd_b != '0) |=> prod_q == W'(W'(1) - $past(opnd_b)));

  a_r4_top_value_zero: assert property (@(posedge clk) disable iff (rst)
    (opnd_a == W'(1) && opnd_b == '0) |=> prod_q == '0);

  a_r5_unit_identity: assert property (@(posedge clk) disable iff (rst)
    (opnd_b == W'(1) && opnd_a != '0) |=> prod_q == $past(opnd_a));
endmodule

bind fmul16 fmul16_chk #(.W(W)) i_fmul16_chk (
  .clk    (clk),
  .rst    (rst),
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .prod_q (prod_q)
);

// File: tb/test_fmul16.sv
module test_fmul16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [15:0] prod_q;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  fmul16 i_fmul16 (
    .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b), .prod_q(prod_q)
  );

  function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b);
    longint ea, eb, r;
    ea = (a == 0) ? 65536 : longint'(a);
    eb = (b == 0) ? 65536 : longint'(b);
    r  = (ea * eb) % 65537;
    return (r == 65536) ? 16'h0000 : 16'(r);
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the next rising edge
  task automatic apply(input logic [15:0] a, input logic [15:0] b, output logic [15:0] r);
    @(negedge clk);
    opnd_a = a;
    opnd_b = b;
    @(posedge clk);
    #1;
    r = prod_q;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    opnd_a = 16'h1234;
    opnd_b = 16'h5678;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset", prod_q, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_latency();
    logic [15:0] r;
    apply(16'h0003, 16'h0005, r);
    check("R2 one-edge latency", r, 16'h000F);
    apply(16'h0003, 16'h0005, r);
    check("R2 steady hold", r, 16'h000F);
  endtask

  task automatic t_zero_op();
    logic [15:0] r;
    apply(16'h0000, 16'hFFFF, r);
    check("R3 0 x FFFF", r, 16'h0002);
    apply(16'h0000, 16'h0002, r);
    check("R3 0 x 2", r, 16'hFFFF);
  endtask

  task automatic t_top_value();
    logic [15:0] r;
    apply(16'h0000, 16'h0001, r);
    check("R4 0 x 1", r, 16'h0000);
    apply(16'h0001, 16'h0000, r);
    check("R4 1 x 0", r, 16'h0000);
  endtask

  task automatic t_general();
    logic [15:0] r, a, b;
    apply(16'hBEEF, 16'h0001, r);
    check("R5 unit", r, 16'hBEEF);
    for (int i = 0; i < 200; i++) begin
      a = 16'($urandom);
      b = 16'($urandom);
      apply(a, b, r);
      check("R5 random", r, model(a, b));
    end
  endtask

  task automatic t_wrap();
    logic [15:0] r;
    apply(16'hFFFF, 16'hFFFF, r);
    check("R6 FFFF x FFFF", r, 16'h0004);
    apply(16'h0000, 16'h0000, r);
    check("R6 0 x 0", r, 16'h0001);
    apply(16'h8000, 16'h0004, r);
    check("R6 8000 x 4", r, model(16'h8000, 16'h0004));
  endtask

  task automatic t_swap();
    logic [15:0] r1, r2, a, b;
    for (int i = 0; i < 20; i++) begin
      a = 16'($urandom);
      b = 16'($urandom);
      apply(a, b, r1);
      apply(b, a, r2);
      check("R7 order", r2, r1);
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_zero_op();
    t_top_value();
    t_general();
    t_wrap();
    t_swap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule